// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects a parameterized set of interrupt request lines and gives a processor one request at a time. A rising edge on a request line marks that line pending, whether or not it is enabled. Software can also mark lines pending or clear them. Among the lines that are both pending and enabled, the block picks the most urgent one. A lower priority value means more urgency, and on equal values the lower line number wins. The chosen line is presented to the processor as a request with a line number.

The processor takes the presented line with an acknowledge. The acknowledge clears that line's pending bit and records the line's priority on an internal stack of active levels. While a handler runs, a pending line is presented only if it is strictly more urgent than the level on top of the stack. Such a line preempts the running handler. Lines of equal or lower urgency wait. An end-of-interrupt pops the stack, and the waiting lines are then compared against the level below.

Configuration uses a simple word-addressed register port. The port has write-one enable set and enable clear words, write-one pending set and pending clear words, and priority words that hold four byte-wide priority fields each.

Top module: `irqc_top`

## Requirements
- R1: Writing word address 0x00+k sets enable bit j of line 32k+j for every 1 in the write data, and 0 bits leave enables unchanged. Reading 0x00+k or 0x20+k returns the enable bits of that word.
- R2: Writing word address 0x20+k clears the enable of line 32k+j for every 1 in bit j, and 0 bits have no effect. A disabled line is no longer presented.
- R3: A rising edge on `irq_i[n]` sets pending bit n one clock later, even while line n is disabled. A disabled pending line is not presented, and it is presented once it is enabled.
- R4: Writing 0x40+k sets pending bits and writing 0x60+k clears pending bits, one bit per line as in R1, and 0 bits have no effect. Reading either address returns the pending bits.
- R5: Priority word w at address 0x80+w holds line n=4w+l in byte lane l (bits 8l+7..8l). Only the upper PRIO_BITS (4) bits of each byte are stored, and the lower bits read as 0.
- R6: Among pending and enabled lines, the one with the smallest priority value is presented. On equal values, the lower line number is presented.
- R7: An acknowledge while `cpu_req_o` is high clears the presented line's pending bit and makes its priority the active level.
- R8: While a handler is active, a line is presented only when its priority value is strictly smaller than the active level. A strictly more urgent line preempts the handler. A line of equal or lower urgency is held back.
- R9: End-of-interrupt returns to the previous active level, or to the idle state when no handler remains. It has no effect when no handler is active.
- R10: After reset, all enables and pending bits are 0, all priorities are 0, no handler is active and `cpu_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_i | input | NUM_IRQ | Request lines; a rising edge marks a line pending |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| cpu_req_o | output | 1 | A line is presented to the processor |
| cpu_irq_id_o | output | $clog2(NUM_IRQ) | Number of the presented line |
| cpu_ack_i | input | 1 | Processor takes the presented line |
| cpu_eoi_i | input | 1 | Processor ends the current handler |

## Verification
A corrupt active-level stack shows up as a preemption decision that is wrong at the ports. A line of equal urgency appears when it should be held back, or a waiting line stays hidden after end-of-interrupt. The bench reads `cpu_req_o` and `cpu_irq_id_o` one clock after each acknowledge or end-of-interrupt, so such a fault shows within a single cycle. A lost or stuck pending or enable bit appears the same way. It shows in the next presented number, and also in the readback of the pending and enable words right after the write or edge that should have changed it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Register region selected by reg_addr[6:5] when reg_addr[7] is 0
  typedef enum logic [1:0] {
    RG_EN_SET   = 2'd0,
    RG_EN_CLR   = 2'd1,
    RG_PEND_SET = 2'd2,
    RG_PEND_CLR = 2'd3
  } reg_region_e;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs import irqc_pkg::*; #(
  parameter int N  = 32,
  parameter int PB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    irq,
  input  logic            wr,
  input  logic [7:0]      addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  input  logic [N-1:0]    ack_clr,
  output logic [N-1:0]    en_o,
  output logic [N-1:0]    pend_o,
  output logic [N*PB-1:0] prio_o
);
  logic [N-1:0]    en_q, en_d, pend_q, pend_d, prev_q;
  logic [N*PB-1:0] prio_q, prio_d;
  logic [N-1:0]    s_en, c_en, s_pd, c_pd;
  logic            en_ce, pend_ce, prio_ce;
  reg_region_e     region;

  assign region = reg_region_e'(addr[6:5]);

  // write decode and next state
  always_comb begin
    s_en = '0; c_en = '0; s_pd = '0; c_pd = '0;
    prio_d = prio_q;
    for (int i = 0; i < N; i++) begin
      if (wr && !addr[7] && addr[4:0] == 5'(i / 32) && wdata[i % 32]) begin
        case (region)
          RG_EN_SET:   s_en[i] = 1'b1;
          RG_EN_CLR:   c_en[i] = 1'b1;
          RG_PEND_SET: s_pd[i] = 1'b1;
          default:     c_pd[i] = 1'b1;
        endcase
      end
      if (wr && addr[7] && addr[6:0] == 7'(i / 4))
        prio_d[i*PB +: PB] = wdata[8*(i%4)+7 -: PB];
    end
    en_d    = (en_q & ~c_en) | s_en;
    pend_d  = (pend_q & ~(c_pd | ack_clr)) | s_pd | (irq & ~prev_q);
    en_ce   = wr && !addr[7] && (region == RG_EN_SET || region == RG_EN_CLR);
    pend_ce = 1'b1;
    prio_ce = wr && addr[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      prev_q <= '0;
      prio_q <= '0;
    end else begin
      if (en_ce)   en_q   <= en_d;
      if (pend_ce) pend_q <= pend_d;
      if (prio_ce) prio_q <= prio_d;
      prev_q <= irq;
    end
  end

  // readback
  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++) begin
      if (addr[7]) begin
        if (addr[6:0] == 7'(i / 4))
          rdata[8*(i%4)+7 -: PB] = prio_q[i*PB +: PB];
      end else if (addr[4:0] == 5'(i / 32)) begin
        rdata[i % 32] = addr[6] ? pend_q[i] : en_q[i];
      end
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign prio_o = prio_q;
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
  parameter int N   = 32,
  parameter int PB  = 4,
  localparam int IDW = $clog2(N)
) (
  input  logic [N-1:0]    elig,
  input  logic [N*PB-1:0] prio,
  output logic            found,
  output logic [IDW-1:0]  best_id,
  output logic [PB-1:0]   best_prio
);
  // Scan from the top so an equal value at a lower index replaces the choice
  always_comb begin
    found     = 1'b0;
    best_id   = '0;
    best_prio = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i] && (!found || prio[i*PB +: PB] <= best_prio)) begin
        found     = 1'b1;
        best_id   = IDW'(i);
        best_prio = prio[i*PB +: PB];
      end
    end
  end
endmodule

// File: rtl/irqc_stack.sv
module irqc_stack #(
  parameter int PB = 4,
  localparam int DEPTH = 1 << PB,
  localparam int DW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [PB-1:0] push_prio,
  output logic [PB-1:0] top_prio,
  output logic          empty,
  output logic [DW-1:0] depth
);
  logic [PB-1:0] mem_q [DEPTH];
  logic [DW-1:0] sp_q, sp_d;
  logic          wr_ce;
  logic [DW-1:0] wr_idx;

  always_comb begin
    sp_d   = sp_q;
    wr_ce  = 1'b0;
    wr_idx = sp_q;
    if (push && pop && sp_q != '0) begin
      wr_ce  = 1'b1;
      wr_idx = sp_q - 1'b1;
    end else if (push && sp_q != DW'(DEPTH)) begin
      wr_ce = 1'b1;
      sp_d  = sp_q + 1'b1;
    end else if (pop && sp_q != '0) begin
      sp_d = sp_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  always_ff @(posedge clk) begin
    if (wr_ce) mem_q[wr_idx[PB-1:0]] <= push_prio;
  end

  assign empty    = (sp_q == '0);
  assign top_prio = empty ? '1 : mem_q[PB'(sp_q - 1'b1)];
  assign depth    = sp_q;
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 4,
  localparam int IDW = $clog2(NUM_IRQ),
  localparam int DW  = $clog2((1 << PRIO_BITS) + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               reg_wr_i,
  input  logic [7:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               cpu_req_o,
  output logic [IDW-1:0]     cpu_irq_id_o,
  input  logic               cpu_ack_i,
  input  logic               cpu_eoi_i
);
  logic rst_meta_q, rst_sync_n;
  logic [NUM_IRQ-1:0]           en, pend, ack_clr;
  logic [NUM_IRQ*PRIO_BITS-1:0] prio;
  logic found, empty, ack_fire, eoi_fire;
  logic [IDW-1:0]       best_id;
  logic [PRIO_BITS-1:0] best_prio, top_prio;
  logic [DW-1:0]        depth;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  irqc_regs #(.N(NUM_IRQ), .PB(PRIO_BITS)) regs_i (
    .clk(clk_i), .rst_n(rst_sync_n), .irq(irq_i),
    .wr(reg_wr_i), .addr(reg_addr_i), .wdata(reg_wdata_i), .rdata(reg_rdata_o),
    .ack_clr(ack_clr), .en_o(en), .pend_o(pend), .prio_o(prio)
  );

  irqc_arb #(.N(NUM_IRQ), .PB(PRIO_BITS)) arb_i (
    .elig(en & pend), .prio(prio),
    .found(found), .best_id(best_id), .best_prio(best_prio)
  );

  irqc_stack #(.PB(PRIO_BITS)) stack_i (
    .clk(clk_i), .rst_n(rst_sync_n), .push(ack_fire), .pop(eoi_fire),
    .push_prio(best_prio), .top_prio(top_prio), .empty(empty), .depth(depth)
  );

  assign cpu_req_o    = found && (empty || best_prio < top_prio);
  assign cpu_irq_id_o = best_id;
  assign ack_fire     = cpu_ack_i && cpu_req_o;
  assign eoi_fire     = cpu_eoi_i && !empty;

  always_comb begin
    ack_clr = '0;
    if (ack_fire) ack_clr[best_id] = 1'b1;
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int N  = 32,
  parameter int PB = 4,
  localparam int IDW = $clog2(N),
  localparam int DW  = $clog2((1 << PB) + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cpu_req,
  input logic [IDW-1:0] cpu_id,
  input logic           cpu_ack,
  input logic           cpu_eoi,
  input logic [N-1:0]   en,
  input logic [N-1:0]   pend,
  input logic [PB-1:0]  req_prio,
  input logic [PB-1:0]  top_prio,
  input logic [DW-1:0]  depth
);
  // R3 R2: only an enabled pending line is ever presented
  p_req_elig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (en[cpu_id] && pend[cpu_id]));

  // R8: while active, only a strictly more urgent line is presented
  p_strict_preempt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && depth != '0) |-> (req_prio < top_prio));

  // R7: acknowledge alone deepens the active stack by one
  p_ack_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_req && !cpu_eoi) |=> (depth == $past(depth) + 1'b1));

  // R9: end-of-interrupt alone on an active handler pops one level
  p_eoi_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_eoi && !cpu_ack && depth != '0) |=> (depth == $past(depth) - 1'b1));

  // R9: end-of-interrupt while idle leaves the stack empty
  p_eoi_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_eoi && !(cpu_ack && cpu_req) && depth == '0) |=> (depth == '0));

  // R8: strict nesting never exceeds one level per priority value
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(1 << PB));
endmodule

bind irqc_top irqc_chk #(.N(NUM_IRQ), .PB(PRIO_BITS)) chk_i (
  .clk(clk_i), .rst_n(rst_sync_n),
  .cpu_req(cpu_req_o), .cpu_id(cpu_irq_id_o),
  .cpu_ack(cpu_ack_i), .cpu_eoi(cpu_eoi_i),
  .en(en), .pend(pend), .req_prio(best_prio), .top_prio(top_prio), .depth(depth)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb_top;
  localparam int N = 32;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req;
  logic [4:0]  id;
  logic        ack = 1'b0, eoi = 1'b0;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  irqc_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cpu_req_o(req), .cpu_irq_id_o(id), .cpu_ack_i(ack), .cpu_eoi_i(eoi)
  );

  // {write addr, write data, read addr, expected read}
  localparam logic [79:0] VEC [12] = '{
    {8'h00, 32'h0000_0101, 8'h00, 32'h0000_0101},  // R1 set
    {8'h00, 32'h0000_0000, 8'h20, 32'h0000_0101},  // R1 zero write, read via clear word
    {8'h20, 32'h0000_0001, 8'h00, 32'h0000_0100},  // R2 clear one
    {8'h20, 32'h0000_0000, 8'h00, 32'h0000_0100},  // R2 zero write
    {8'h20, 32'h0000_0100, 8'h00, 32'h0000_0000},  // R2 clear rest
    {8'h40, 32'h8000_0010, 8'h60, 32'h8000_0010},  // R4 set pending
    {8'h60, 32'h0000_0010, 8'h40, 32'h8000_0000},  // R4 clear pending
    {8'h60, 32'h8000_0000, 8'h40, 32'h0000_0000},  // R4 clear pending
    {8'h80, 32'hFFFF_FFFF, 8'h80, 32'hF0F0_F0F0},  // R5 low bits read 0
    {8'h87, 32'h1234_5678, 8'h87, 32'h1030_5070},  // R5 last word
    {8'h80, 32'h0000_0000, 8'h80, 32'h0000_0000},  // R5 restore
    {8'h87, 32'h0000_0000, 8'h87, 32'h0000_0000}   // R5 restore
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk); irq = m;
    @(negedge clk); irq = '0; #1;
  endtask

  task automatic cpu_op(input bit a, input bit e);
    @(negedge clk); ack = a; eoi = e;
    @(negedge clk); ack = 1'b0; eoi = 1'b0; #1;
  endtask

  task automatic chk_req(input string tag, input bit r, input logic [4:0] i);
    #1;
    chk({tag, " req"}, 32'(req), 32'(r));
    if (r) chk({tag, " id"}, 32'(id), 32'(i));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk_req("R10", 1'b0, 5'd0);
    reg_read(8'h00, d); chk("R10 enables", d, 32'h0);
    reg_read(8'h40, d); chk("R10 pending", d, 32'h0);
    reg_read(8'h81, d); chk("R10 priority", d, 32'h0);

    // register table walk
    for (int k = 0; k < 12; k++) begin
      reg_write(VEC[k][79:72], VEC[k][71:40]);
      reg_read(VEC[k][39:32], d);
      chk($sformatf("R1 R2 R4 R5 table row %0d", k), d, VEC[k][31:0]);
    end

    // priorities: line3=0x40, line5=0x40, line7=0x20, line9=0x80
    reg_write(8'h80, 32'h4000_0000);
    reg_write(8'h81, 32'h2000_4000);
    reg_write(8'h82, 32'h0000_8000);
    reg_read(8'h81, d); chk("R5 lane placement", d, 32'h2000_4000);

    // R3 pending while disabled
    pulse(32'h0000_0220);
    chk_req("R3 disabled", 1'b0, 5'd0);
    reg_read(8'h40, d); chk("R3 pending latched", d, 32'h0000_0220);

    reg_write(8'h00, 32'h0000_02A8);
    chk_req("R3 R6 after enable", 1'b1, 5'd5);

    cpu_op(1'b1, 1'b0);
    reg_read(8'h40, d); chk("R7 ack clears pending", d, 32'h0000_0200);
    chk_req("R8 lower held", 1'b0, 5'd0);

    pulse(32'h0000_0008);
    chk_req("R8 equal held", 1'b0, 5'd0);
    pulse(32'h0000_0080);
    chk_req("R8 preempt", 1'b1, 5'd7);

    cpu_op(1'b1, 1'b0);
    chk_req("R7 after nested ack", 1'b0, 5'd0);
    reg_read(8'h40, d); chk("R7 pending after nested ack", d, 32'h0000_0208);

    cpu_op(1'b0, 1'b1);
    chk_req("R9 back to level 0x40", 1'b0, 5'd0);
    cpu_op(1'b0, 1'b1);
    chk_req("R9 idle", 1'b1, 5'd3);

    reg_write(8'h40, 32'h0000_0020);
    chk_req("R6 tie lower id", 1'b1, 5'd3);
    reg_write(8'h60, 32'h0000_0008);
    chk_req("R4 clear pending", 1'b1, 5'd5);
    reg_write(8'h20, 32'h0000_0020);
    chk_req("R2 disabled line dropped", 1'b1, 5'd9);

    cpu_op(1'b0, 1'b1);
    chk_req("R9 eoi while idle", 1'b1, 5'd9);
    reg_read(8'h40, d); chk("R9 pending unchanged", d, 32'h0000_0220);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule